// File: doc/BRIEF.md
# Serial Port Interrupt Mask and Status Bank

This block holds the interrupt control registers of a serial port. Software never writes the mask register directly. It writes ones to a set alias to turn sources on, and ones to a clear alias to turn them off. The mask itself can only be read.

The data path delivers single-cycle event pulses, one per source. A pulse is latched into a sticky status register only when its mask bit is set. Software clears a status bit by writing a one to it.

A separate channel-status view shows four raw FIFO condition levels as they are, whatever the mask holds. A single registered interrupt line goes high whenever any latched status bit is also enabled in the mask. Register access is a plain one-cycle write strobe plus a combinational read port addressed by byte offset.

Top module: `uart_irq_bank`

## Requirements
- R1: A write to offset 0x08 sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R2: A write to offset 0x0C clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: A read of offset 0x08 or 0x0C returns 0.
- R4: A write to the mask offset (0x10) changes nothing. A write to the channel-status offset (0x2C) also changes nothing.
- R5: Reads return the mask at 0x10, the latched status at 0x14 and the channel status at 0x2C. Every other offset reads 0. Data bits 13 and above always read 0.
- R6: Event bit n is latched into status bit n at a clock edge only if mask bit n is 1 before that edge. The sources are: bit 0 RX trigger, 1 RX empty, 2 RX full, 3 TX empty, 4 TX full, 5 overrun, 6 framing, 7 parity, 8 RX timeout, and bits 9 to 12 spare.
- R7: A write to 0x14 clears each status bit whose data bit is 1. A data bit of 0 leaves the status bit unchanged.
- R8: If an enabled event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: `irq` equals the OR over all bits of status AND mask, taken before the previous clock edge. It is one register stage behind the register state.
- R10: Clearing a mask bit does not clear a status bit that is already latched. `irq` drops one edge after the mask clear takes effect.
- R11: The channel status at 0x2C places the raw level inputs at fixed bits, independent of the mask:
  - raw_lvl[0] (RX trigger) appears at bit 0;
  - raw_lvl[1] (RX empty) appears at bit 1;
  - raw_lvl[2] (TX empty) appears at bit 3;
  - raw_lvl[3] (TX full) appears at bit 4;
  - all other bits read 0.
- R12: After reset, the mask, the status register and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle register write strobe |
| reg_addr | input | 8 | Byte offset used for both read and write |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Combinational read data for reg_addr |
| evt_in | input | REG_W (13) | Single-cycle event pulses, one per source |
| raw_lvl | input | 4 | Raw condition levels: RX trigger, RX empty, TX empty, TX full |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is two updates landing on one status bit in the same cycle. The first is an enabled event meeting a clearing write. The second is a mask clear arriving after a bit has latched, which must drop `irq` while the status bit stays set.

The bench reaches both with a single step task that drives the write strobe and the event vector on the same falling edge. It then reads status and samples `irq` on the following falling edges, one edge apart, so the one-cycle lag of the interrupt register is visible. Per-bit sweeps repeat this latch, clear and interrupt sequence for all thirteen sources.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int REG_W  = 13;
    localparam int LVL_W  = 4;

    // Byte offsets of the bank
    localparam logic [ADDR_W-1:0] OFS_SET  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CHAN = 8'h2C;

    // Source bit positions shared by mask, status and channel view
    localparam int BIT_RX_TRIG  = 0;
    localparam int BIT_RX_EMPTY = 1;
    localparam int BIT_RX_FULL  = 2;
    localparam int BIT_TX_EMPTY = 3;
    localparam int BIT_TX_FULL  = 4;
    localparam int BIT_OVERRUN  = 5;
    localparam int BIT_FRAMING  = 6;
    localparam int BIT_PARITY   = 7;
    localparam int BIT_RX_TOUT  = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SET,
        SEL_CLR,
        SEL_MASK,
        SEL_STAT,
        SEL_CHAN
    } reg_sel_e;

    typedef struct packed {
        logic set_mask;
        logic clr_mask;
        logic clr_stat;
    } reg_cmd_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_SET:  s = SEL_SET;
            OFS_CLR:  s = SEL_CLR;
            OFS_MASK: s = SEL_MASK;
            OFS_STAT: s = SEL_STAT;
            OFS_CHAN: s = SEL_CHAN;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [REG_W-1:0] chan_view(input logic [LVL_W-1:0] lvl);
        logic [REG_W-1:0] v;
        v = '0;
        v[BIT_RX_TRIG]  = lvl[0];
        v[BIT_RX_EMPTY] = lvl[1];
        v[BIT_TX_EMPTY] = lvl[2];
        v[BIT_TX_FULL]  = lvl[3];
        return v;
    endfunction

endpackage

// File: rtl/uirq_decode.sv
module uirq_decode
    import uirq_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    output reg_cmd_t          cmd,
    output reg_sel_e          rd_sel
);

    reg_sel_e sel;

    always_comb begin
        sel          = decode_ofs(reg_addr);
        rd_sel       = sel;
        cmd.set_mask = wr_en && (sel == SEL_SET);
        cmd.clr_mask = wr_en && (sel == SEL_CLR);
        cmd.clr_stat = wr_en && (sel == SEL_STAT);
    end

endmodule

// File: rtl/uirq_mask.sv
module uirq_mask #(
    parameter int REG_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [REG_W-1:0] bits,
    output logic [REG_W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (set_stb) begin
            mask_q <= mask_q | bits;
        end else if (clr_stb) begin
            mask_q <= mask_q & ~bits;
        end
    end

endmodule

// File: rtl/uirq_status.sv
module uirq_status #(
    parameter int REG_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] evt_in,
    input  logic [REG_W-1:0] mask_q,
    input  logic             clr_stb,
    input  logic [REG_W-1:0] bits,
    output logic [REG_W-1:0] stat_q
);

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        // an enabled event outranks a same-cycle clear
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[b] <= 1'b0;
            end else if (evt_in[b] && mask_q[b]) begin
                stat_q[b] <= 1'b1;
            end else if (clr_stb && bits[b]) begin
                stat_q[b] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_irq_bank.sv
module uart_irq_bank
    import uirq_pkg::*;
#(
    parameter int REG_W  = uirq_pkg::REG_W,
    parameter int DATA_W = uirq_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [REG_W-1:0]  evt_in,
    input  logic [LVL_W-1:0]  raw_lvl,
    output logic              irq
);

    reg_cmd_t         cmd;
    reg_sel_e         rd_sel;
    logic [REG_W-1:0] wbits;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] chan_bits;
    logic             unused_hi;

    assign wbits     = wr_data[REG_W-1:0];
    assign unused_hi = ^wr_data[DATA_W-1:REG_W];

    uirq_decode dec_i (
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .cmd      (cmd),
        .rd_sel   (rd_sel)
    );

    uirq_mask #(.REG_W(REG_W)) mask_i (
        .clk     (clk),
        .rst     (rst),
        .set_stb (cmd.set_mask),
        .clr_stb (cmd.clr_mask),
        .bits    (wbits),
        .mask_q  (mask_q)
    );

    uirq_status #(.REG_W(REG_W)) stat_i (
        .clk     (clk),
        .rst     (rst),
        .evt_in  (evt_in),
        .mask_q  (mask_q),
        .clr_stb (cmd.clr_stat),
        .bits    (wbits),
        .stat_q  (stat_q)
    );

    assign chan_bits = REG_W'(chan_view(raw_lvl));

    always_comb begin
        case (rd_sel)
            SEL_MASK: rd_data = DATA_W'(mask_q);
            SEL_STAT: rd_data = DATA_W'(stat_q);
            SEL_CHAN: rd_data = DATA_W'(chan_bits);
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |(stat_q & mask_q);
        end
    end

endmodule

// File: rtl/uart_irq_bank_chk.sv
module uart_irq_bank_chk
    import uirq_pkg::*;
#(
    parameter int REG_W  = 13,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [REG_W-1:0]  evt_in,
    input logic              irq,
    input logic [REG_W-1:0]  mask_q,
    input logic [REG_W-1:0]  stat_q
);

    logic mask_wr;
    logic stat_wr;
    assign mask_wr = wr_en && ((reg_addr == OFS_SET) || (reg_addr == OFS_CLR));
    assign stat_wr = wr_en && (reg_addr == OFS_STAT);

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q));

    // R1
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == OFS_SET) |=> ((mask_q & $past(wr_data[REG_W-1:0])) == $past(wr_data[REG_W-1:0])));

    // R2
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == OFS_CLR) |=> ((mask_q & $past(wr_data[REG_W-1:0])) == '0));

    // R3
    alias_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((reg_addr == OFS_SET) || (reg_addr == OFS_CLR)) |-> (rd_data == '0));

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[DATA_W-1:REG_W] == '0);

    // R6
    latch_gated_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(mask_q)) == '0));

    // R7
    stat_fall_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~stat_q & $past(stat_q) & ~($past(wr_data[REG_W-1:0]) & {REG_W{$past(stat_wr)}})) == '0));

    // R8
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(evt_in & mask_q)) == $past(evt_in & mask_q)));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(stat_q & mask_q)) |=> irq);

    // R9
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(stat_q & mask_q)) |=> !irq);

endmodule

bind uart_irq_bank uart_irq_bank_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .evt_in   (evt_in),
    .irq      (irq),
    .mask_q   (mask_q),
    .stat_q   (stat_q)
);

// File: tb/uart_irq_bank_tb_top.sv
module uart_irq_bank_tb_top;

    localparam int RW = 13;
    localparam logic [7:0] A_SET  = 8'h08;
    localparam logic [7:0] A_CLR  = 8'h0C;
    localparam logic [7:0] A_MASK = 8'h10;
    localparam logic [7:0] A_STAT = 8'h14;
    localparam logic [7:0] A_CHAN = 8'h2C;
    localparam logic [31:0] ALL = 32'h1FFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [RW-1:0] evt_in = '0;
    logic [3:0]    raw_lvl = 4'h0;
    logic          irq;

    int vectors = 0;
    int fails   = 0;

    always #10 clk = ~clk;

    uart_irq_bank dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .evt_in   (evt_in),
        .raw_lvl  (raw_lvl),
        .irq      (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic [RW-1:0] ev);
        @(negedge clk);
        wr_en = we; reg_addr = a; wr_data = d; evt_in = ev;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; evt_in = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic logic [31:0] chan_exp(input logic [3:0] l);
        return {27'd0, l[3], l[2], 1'b0, l[1], l[0]};
    endfunction

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] m_mask;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        rd(A_MASK, v); chk("R12 mask", v, 0);
        rd(A_STAT, v); chk("R12 status", v, 0);
        chk("R12 irq", {31'd0, irq}, 0);

        // R1 set sweep, accumulating
        m_mask = 0;
        for (int b = 0; b < RW; b++) begin
            step(1'b1, A_SET, 32'd1 << b, '0);
            m_mask = m_mask | (32'd1 << b);
            rd(A_MASK, v); chk("R1 set", v, m_mask);
        end
        step(1'b1, A_SET, 32'd0, '0);
        rd(A_MASK, v); chk("R1 zero bits", v, m_mask);

        // R2 clear even bits
        for (int b = 0; b < RW; b += 2) begin
            step(1'b1, A_CLR, 32'd1 << b, '0);
            m_mask = m_mask & ~(32'd1 << b);
            rd(A_MASK, v); chk("R2 clear", v, m_mask);
        end
        step(1'b1, A_CLR, 32'd0, '0);
        rd(A_MASK, v); chk("R2 zero bits", v, m_mask);

        // R3 alias reads
        rd(A_SET, v); chk("R3 set alias read", v, 0);
        rd(A_CLR, v); chk("R3 clear alias read", v, 0);

        // R4 direct writes ignored
        step(1'b1, A_MASK, 32'hFFFF_FFFF, '0);
        rd(A_MASK, v); chk("R4 mask write ignored", v, m_mask);
        raw_lvl = 4'b0101;
        step(1'b1, A_CHAN, 32'hFFFF_FFFF, '0);
        rd(A_CHAN, v); chk("R4 chan write ignored", v, chan_exp(4'b0101));
        rd(A_STAT, v); chk("R4 status untouched", v, 0);

        // R5 full address sweep
        for (int a = 0; a < 256; a++) begin
            logic [31:0] e;
            e = (a == 8'h10) ? m_mask : (a == 8'h2C) ? chan_exp(4'b0101) : 32'd0;
            rd(8'(a), v); chk("R5 address map", v, e);
        end

        // R6 events with mask fully off
        step(1'b1, A_CLR, ALL, '0);
        step(1'b0, 8'h00, 0, '1);
        rd(A_STAT, v); chk("R6 masked ignored", v, 0);
        @(negedge clk);
        chk("R6 irq stays low", {31'd0, irq}, 0);

        // R6 R7 R9 per-bit sequence
        for (int b = 0; b < RW; b++) begin
            step(1'b1, A_CLR, ALL, '0);
            step(1'b1, A_SET, 32'd1 << b, '0);
            step(1'b0, 8'h00, 0, '1);
            rd(A_STAT, v); chk("R6 latch only enabled", v, 32'd1 << b);
            chk("R9 irq lags", {31'd0, irq}, 0);
            @(negedge clk);
            chk("R9 irq high", {31'd0, irq}, 1);
            step(1'b1, A_STAT, ~(32'd1 << b), '0);
            rd(A_STAT, v); chk("R7 zero no effect", v, 32'd1 << b);
            step(1'b1, A_STAT, 32'd1 << b, '0);
            rd(A_STAT, v); chk("R7 w1c", v, 0);
            @(negedge clk);
            chk("R9 irq low", {31'd0, irq}, 0);
        end

        // R8 collision
        step(1'b1, A_CLR, ALL, '0);
        step(1'b1, A_SET, 32'h8, '0);
        step(1'b0, 8'h00, 0, 13'h8);
        step(1'b1, A_STAT, 32'h8, 13'h8);
        rd(A_STAT, v); chk("R8 event wins", v, 32'h8);
        step(1'b1, A_STAT, 32'h8, '0);
        rd(A_STAT, v); chk("R8 clears after", v, 0);

        // R10 mask clear after latch
        step(1'b1, A_SET, 32'h100, '0);
        step(1'b0, 8'h00, 0, 13'h100);
        @(negedge clk);
        chk("R10 irq set", {31'd0, irq}, 1);
        step(1'b1, A_CLR, 32'h100, '0);
        rd(A_STAT, v); chk("R10 status kept", v, 32'h100);
        chk("R10 irq one more cycle", {31'd0, irq}, 1);
        @(negedge clk);
        chk("R10 irq dropped", {31'd0, irq}, 0);
        step(1'b1, A_STAT, ALL, '0);

        // R11 channel view over all levels, mask off and on
        step(1'b1, A_CLR, ALL, '0);
        for (int l = 0; l < 16; l++) begin
            raw_lvl = 4'(l);
            rd(A_CHAN, v); chk("R11 chan mask off", v, chan_exp(4'(l)));
        end
        step(1'b1, A_SET, ALL, '0);
        for (int l = 0; l < 16; l++) begin
            raw_lvl = 4'(l);
            rd(A_CHAN, v); chk("R11 chan mask on", v, chan_exp(4'(l)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule